// File: doc/BRIEF.md
# Banked Memory Window Address Mapper

This block sits between a CPU with a 16-bit address bus and a 512 KB physical RAM. It decodes every CPU access into one of four targets and raises the matching select. The first 48 KB of the CPU space maps straight onto the bottom of physical RAM. A 2 KB window inside the peripheral area is redirected through an 8-bit bank register, so any of the 256 banks of 2 KB in physical RAM can be reached through it. The rest of the peripheral area raises an I/O select. The top 12 KB is split into three 4 KB ROM selects.

The bank register is loaded by a CPU write to one peripheral port address. It clears on reset. The new bank applies to accesses in the cycle after the write. All selects and the physical address are combinational from the current CPU address, so the memories and peripherals behind the block see the decode in the same cycle as the request.

Top module: `banked_window_mapper`

## Requirements
- R1: With req_i high and addr_i below 0xC000, ram_sel_o is 1 and ram_addr_o equals addr_i zero-extended to 19 bits.
- R2: With req_i high and addr_i in 0xC400..0xCBFF, ram_sel_o is 1 and ram_addr_o equals {bank, addr_i - 0xC400}. Bank is the 8-bit bank register and fills bits 18:11, and the 11-bit offset fills bits 10:0.
- R3: With req_i high and addr_i in 0xC000..0xC3FF or 0xCC00..0xCFFF, io_sel_o is 1 and ram_sel_o is 0. The window takes priority over the I/O decode.
- R4: On a read with req_i high, rom_sel_o is one-hot with bit k set for addr_i in 0xD000 + k*0x1000 .. 0xDFFF + k*0x1000, for k = 0, 1, 2.
- R5: A write to 0xD000..0xFFFF is ignored. No select is raised and ram_we_o stays 0.
- R6: After reset the bank register is 0, so the window maps onto physical 0x00000..0x007FF.
- R7: A write with req_i high to address 0xC000 loads data_i into the bank register, and the new bank applies from the next cycle. Reads of 0xC000 and writes to any other I/O address leave the bank register unchanged.
- R8: With req_i low, every select and ram_we_o are 0.
- R9: At most one of ram_sel_o, io_sel_o and the rom_sel_o bits is 1 in any cycle. ram_addr_o is 0 whenever ram_sel_o is 0.
- R10: ram_we_o is 1 exactly when req_i and wr_i are high and the address is RAM-mapped (direct region or window).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | CPU memory access valid this cycle |
| wr_i | input | 1 | Access is a write |
| addr_i | input | 16 | CPU address |
| data_i | input | 8 | CPU write data (bank register source) |
| ram_sel_o | output | 1 | Physical RAM select |
| ram_we_o | output | 1 | Physical RAM write enable |
| ram_addr_o | output | 19 | Physical RAM byte address |
| io_sel_o | output | 1 | I/O area select |
| rom_sel_o | output | 3 | One-hot ROM selects |

## Verification
The assertions check several properties on every cycle: that the selects never overlap, that ROM selects never fire on a write, that a window hit carries the live bank in the upper address bits, and that the bank register changes only on a write to its port and then holds the written byte. Some behaviour can only be shown by the bench's scenarios. These are the exact address arithmetic at the region edges (0xBFFF, 0xC3FF/0xC400, 0xCBFF/0xCC00, 0xCFFF/0xD000, 0xFFFF), the aliasing of bank 0 onto the direct region, the reset value of the bank, and that non-port I/O writes and port reads leave the mapping alone.

// File: rtl/bmap_pkg.sv
package bmap_pkg;
  typedef enum logic [2:0] {
    RG_NONE   = 3'd0,
    RG_DIRECT = 3'd1,
    RG_WINDOW = 3'd2,
    RG_IO     = 3'd3,
    RG_ROM    = 3'd4
  } region_e;

  localparam int unsigned DIRECT_TOP = 32'h0000_C000;
  localparam int unsigned IO_BASE    = 32'h0000_C000;
  localparam int unsigned IO_TOP     = 32'h0000_D000;
  localparam int unsigned WIN_BASE   = 32'h0000_C400;
  localparam int unsigned ROM_BASE   = 32'h0000_D000;
  localparam int unsigned BANK_PORT  = 32'h0000_C000;
endpackage

// File: rtl/bmap_region_dec.sv
module bmap_region_dec
  import bmap_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned WIN_W     = 11,
  parameter int unsigned ROM_N     = 3,
  parameter int unsigned ROM_AW    = 12,
  localparam int unsigned ROM_IDX_W = (ROM_N > 1) ? $clog2(ROM_N) : 1
) (
  input  logic [ADDR_W-1:0]    addr_i,
  output region_e              region_o,
  output logic [ROM_IDX_W-1:0] rom_idx_o
);
  localparam int unsigned WinTop = WIN_BASE + (32'd1 << WIN_W);
  localparam int unsigned RomTop = ROM_BASE + (ROM_N << ROM_AW);

  logic [31:0] a;
  assign a = 32'(addr_i);

  // window is checked before the I/O area: it lives inside it
  always_comb begin
    region_o = RG_NONE;
    if (a < DIRECT_TOP)                  region_o = RG_DIRECT;
    else if (a >= WIN_BASE && a < WinTop) region_o = RG_WINDOW;
    else if (a >= IO_BASE && a < IO_TOP)  region_o = RG_IO;
    else if (a >= ROM_BASE && a < RomTop) region_o = RG_ROM;
  end

  assign rom_idx_o = ROM_IDX_W'((a - ROM_BASE) >> ROM_AW);
endmodule

// File: rtl/bmap_bank_reg.sv
module bmap_bank_reg #(
  parameter int unsigned BANK_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [BANK_W-1:0] data_i,
  output logic [BANK_W-1:0] bank_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   bank_o <= '0;
    else if (ld_i) bank_o <= data_i;
  end
endmodule

// File: rtl/bmap_phys_addr.sv
module bmap_phys_addr
  import bmap_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned BANK_W = 8,
  parameter int unsigned WIN_W  = 11,
  localparam int unsigned PHYS_W = BANK_W + WIN_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BANK_W-1:0] bank_i,
  input  region_e           region_i,
  input  logic              ram_sel_i,
  output logic [PHYS_W-1:0] phys_o
);
  logic [WIN_W-1:0] win_off;
  assign win_off = WIN_W'(32'(addr_i) - WIN_BASE);

  always_comb begin
    phys_o = '0;
    if (ram_sel_i) begin
      if (region_i == RG_WINDOW) phys_o = {bank_i, win_off};
      else                       phys_o = PHYS_W'(addr_i);
    end
  end
endmodule

// File: rtl/bmap_sel_gen.sv
module bmap_sel_gen
  import bmap_pkg::*;
#(
  parameter int unsigned ROM_N     = 3,
  localparam int unsigned ROM_IDX_W = (ROM_N > 1) ? $clog2(ROM_N) : 1
) (
  input  logic                 req_i,
  input  logic                 wr_i,
  input  region_e              region_i,
  input  logic [ROM_IDX_W-1:0] rom_idx_i,
  output logic                 ram_sel_o,
  output logic                 ram_we_o,
  output logic                 io_sel_o,
  output logic [ROM_N-1:0]     rom_sel_o
);
  logic rom_rd;

  assign ram_sel_o = req_i && (region_i == RG_DIRECT || region_i == RG_WINDOW);
  assign ram_we_o  = ram_sel_o && wr_i;
  assign io_sel_o  = req_i && (region_i == RG_IO);
  assign rom_rd    = req_i && !wr_i && (region_i == RG_ROM);

  for (genvar k = 0; k < ROM_N; k++) begin : g_rom
    assign rom_sel_o[k] = rom_rd && (rom_idx_i == ROM_IDX_W'(k));
  end
endmodule

// File: rtl/banked_window_mapper.sv
module banked_window_mapper
  import bmap_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned BANK_W = 8,
  parameter int unsigned WIN_W  = 11,
  parameter int unsigned ROM_N  = 3,
  parameter int unsigned ROM_AW = 12,
  localparam int unsigned PHYS_W    = BANK_W + WIN_W,
  localparam int unsigned ROM_IDX_W = (ROM_N > 1) ? $clog2(ROM_N) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BANK_W-1:0] data_i,
  output logic              ram_sel_o,
  output logic              ram_we_o,
  output logic [PHYS_W-1:0] ram_addr_o,
  output logic              io_sel_o,
  output logic [ROM_N-1:0]  rom_sel_o
);
  region_e              region;
  logic [ROM_IDX_W-1:0] rom_idx;
  logic [BANK_W-1:0]    bank_q;
  logic                 bank_ld;

  bmap_region_dec #(
    .ADDR_W(ADDR_W), .WIN_W(WIN_W), .ROM_N(ROM_N), .ROM_AW(ROM_AW)
  ) u_dec (
    .addr_i(addr_i), .region_o(region), .rom_idx_o(rom_idx)
  );

  assign bank_ld = req_i && wr_i && (32'(addr_i) == BANK_PORT);

  bmap_bank_reg #(.BANK_W(BANK_W)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(bank_ld), .data_i(data_i), .bank_o(bank_q)
  );

  bmap_sel_gen #(.ROM_N(ROM_N)) u_sel (
    .req_i(req_i), .wr_i(wr_i), .region_i(region), .rom_idx_i(rom_idx),
    .ram_sel_o(ram_sel_o), .ram_we_o(ram_we_o), .io_sel_o(io_sel_o), .rom_sel_o(rom_sel_o)
  );

  bmap_phys_addr #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .WIN_W(WIN_W)) u_phys (
    .addr_i(addr_i), .bank_i(bank_q), .region_i(region), .ram_sel_i(ram_sel_o),
    .phys_o(ram_addr_o)
  );

  // R9
  a_r9_one_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ram_sel_o, io_sel_o, rom_sel_o}));
  a_r9_addr_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_sel_o |-> ram_addr_o == '0);
  // R5
  a_r5_rom_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> rom_sel_o == '0);
  // R8
  a_r8_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> !ram_sel_o && !ram_we_o && !io_sel_o && rom_sel_o == '0);
  // R2
  a_r2_window_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_sel_o && region == RG_WINDOW) |-> ram_addr_o[PHYS_W-1:WIN_W] == bank_q);
  // R7
  a_r7_bank_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && wr_i && io_sel_o && 32'(addr_i) == BANK_PORT) |=> bank_q == $past(data_i));
  a_r7_bank_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && wr_i && io_sel_o && 32'(addr_i) == BANK_PORT) |=> $stable(bank_q));
endmodule

// File: tb/banked_window_mapper_bench.sv
module banked_window_mapper_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    string       tag;
    logic [15:0] addr;
    logic        ram_sel;
    logic        ram_we;
    logic [18:0] ram_addr;
    logic        io_sel;
    logic [2:0]  rom_sel;
  } exp_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [7:0]  data_i = '0;
  logic        ram_sel_o, ram_we_o, io_sel_o;
  logic [18:0] ram_addr_o;
  logic [2:0]  rom_sel_o;

  int   n_tests = 0;
  int   n_fail  = 0;
  logic [7:0] bank_m = 8'h00;
  exp_t q[$];
  event drv_ev;
  bit   done = 0;

  banked_window_mapper u_banked_window_mapper (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .wr_i(wr_i), .addr_i(addr_i),
    .data_i(data_i), .ram_sel_o(ram_sel_o), .ram_we_o(ram_we_o), .ram_addr_o(ram_addr_o),
    .io_sel_o(io_sel_o), .rom_sel_o(rom_sel_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // expectation built from the address map in the requirements
  function automatic exp_t model(string tag, logic req, logic wr, logic [15:0] a);
    exp_t e;
    e.tag = tag; e.addr = a;
    e.ram_sel = 0; e.ram_we = 0; e.ram_addr = '0; e.io_sel = 0; e.rom_sel = '0;
    if (req) begin
      if (a < 16'hC000) begin
        e.ram_sel = 1; e.ram_addr = {3'b000, a};
      end else if (a >= 16'hC400 && a <= 16'hCBFF) begin
        e.ram_sel = 1; e.ram_addr = {bank_m, 11'(a - 16'hC400)};
      end else if (a < 16'hD000) begin
        e.io_sel = 1;
      end else if (!wr) begin
        if (a < 16'hE000)      e.rom_sel = 3'b001;
        else if (a < 16'hF000) e.rom_sel = 3'b010;
        else                   e.rom_sel = 3'b100;
      end
      e.ram_we = e.ram_sel && wr;
    end
    return e;
  endfunction

  task automatic drive(string tag, logic req, logic wr, logic [15:0] a, logic [7:0] d);
    @(negedge clk_i);
    req_i = req; wr_i = wr; addr_i = a; data_i = d;
    q.push_back(model(tag, req, wr, a));
    if (req && wr && a == 16'hC000 && rst_ni) bank_m = d;
    -> drv_ev;
  endtask

  always @(drv_ev) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_tests++;
      if (ram_sel_o !== e.ram_sel || ram_we_o !== e.ram_we || ram_addr_o !== e.ram_addr ||
          io_sel_o !== e.io_sel || rom_sel_o !== e.rom_sel) begin
        n_fail++;
        $display("FAIL %s addr=%h actual ram_sel=%b we=%b ram_addr=%h io=%b rom=%b expected ram_sel=%b we=%b ram_addr=%h io=%b rom=%b",
                 e.tag, e.addr, ram_sel_o, ram_we_o, ram_addr_o, io_sel_o, rom_sel_o,
                 e.ram_sel, e.ram_we, e.ram_addr, e.io_sel, e.rom_sel);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R6: bank register reads 0 in and after reset
    drive("R6 reset window", 1, 0, 16'hC400, 8'h00);
    drive("R6 reset window top", 1, 0, 16'hCBFF, 8'h00);
    @(negedge clk_i); rst_ni = 1'b1;
    drive("R6 after reset", 1, 0, 16'hC7FF, 8'h00);
    // R1 direct region
    drive("R1 bottom", 1, 0, 16'h0000, 8'h00);
    drive("R1 top", 1, 0, 16'hBFFF, 8'h00);
    drive("R1 R10 write", 1, 1, 16'h1234, 8'h00);
    // R3 I/O edges and window priority
    drive("R3 io low", 1, 0, 16'hC000, 8'h00);
    drive("R3 io below win", 1, 0, 16'hC3FF, 8'h00);
    drive("R3 io above win", 1, 0, 16'hCC00, 8'h00);
    drive("R3 io top", 1, 0, 16'hCFFF, 8'h00);
    // R7 bank load and hold
    drive("R7 bank write", 1, 1, 16'hC000, 8'hA5);
    drive("R7 R2 win base", 1, 0, 16'hC400, 8'h00);
    drive("R7 R2 win top", 1, 0, 16'hCBFF, 8'h00);
    drive("R7 other io write", 1, 1, 16'hC001, 8'h11);
    drive("R7 bank kept", 1, 0, 16'hC500, 8'h00);
    drive("R7 port read", 1, 0, 16'hC000, 8'h22);
    drive("R7 bank kept after read", 1, 0, 16'hC400, 8'h00);
    drive("R7 idle port write", 0, 1, 16'hC000, 8'h33);
    drive("R7 bank kept after idle", 1, 0, 16'hC401, 8'h00);
    drive("R7 bank ff", 1, 1, 16'hC000, 8'hFF);
    drive("R2 top of memory", 1, 0, 16'hCBFF, 8'h00);
    drive("R2 R10 window write", 1, 1, 16'hC7FF, 8'h00);
    drive("R7 bank back to 0", 1, 1, 16'hC000, 8'h00);
    drive("R2 alias of direct", 1, 0, 16'hC6AB, 8'h00);
    // R4 ROM reads
    drive("R4 rom0 low", 1, 0, 16'hD000, 8'h00);
    drive("R4 rom0 high", 1, 0, 16'hDFFF, 8'h00);
    drive("R4 rom1", 1, 0, 16'hE000, 8'h00);
    drive("R4 rom2 low", 1, 0, 16'hF000, 8'h00);
    drive("R4 rom2 high", 1, 0, 16'hFFFF, 8'h00);
    // R5 ROM writes ignored
    drive("R5 rom0 write", 1, 1, 16'hD000, 8'h00);
    drive("R5 rom2 write", 1, 1, 16'hF123, 8'h00);
    // R8 idle
    drive("R8 idle direct", 0, 0, 16'h1000, 8'h00);
    drive("R8 idle rom", 0, 0, 16'hE000, 8'h00);
    drive("R8 R9 idle window write", 0, 1, 16'hC400, 8'h00);
    @(negedge clk_i);
    req_i = 0; wr_i = 0;
    repeat (2) @(negedge clk_i);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule